// File: doc/BRIEF.md
# Processor Interrupt Entry Sequencer

This block sits next to a processor core and decides, at each instruction boundary the core signals, whether an exception or interrupt is to be taken. Three sources compete for service: a reset request, a non-maskable request, and a 3-bit pending level supplied by an external interrupt controller. When an entry is taken, the block stores the core's return address and status word on the stack through a memory-write port. It then hands the core a new program counter, status word and stack pointer. For a maskable entry, it also pulses an acknowledge that carries the level being served.

The handler address for a maskable level is a fixed base plus a 16-bit vector held in a small register bank. Software reads and writes that bank over a halfword register bus. The bank also exposes two read-only words, a memory-control word and a mode word. A maskable request is not consumed by delivery. It stays pending until the controller supplies a new level. The core's status word, which is updated on entry, keeps the same request from being taken twice.

Top module: `irq_entry_unit`

## Requirements
- R1: After reset, every vector register reads 0. No memory write, entry or acknowledge is produced, and no maskable level is pending (level code 7).
- R2: Vector register k (k = 0..6) sits at byte offset 4*k. A write with size 2 stores `reg_wdata`, where bits [7:0] are the byte at the lower address. A read returns the stored halfword with `reg_rvalid` high in the cycle after `reg_rd`.
- R3: A register write whose size is not 2 bytes changes nothing and raises `reg_err` for one cycle in the cycle after the write. A 2-byte write leaves `reg_err` low.
- R4: Offset 0x20 reads the memory-control constant and offset 0x40 reads the mode constant. Writes to those offsets, and to any other offset outside the vector bank, are ignored. A read of an undecoded offset returns 0.
- R5: When several sources are pending at a boundary, reset wins over the non-maskable request, and the non-maskable request wins over a maskable level.
- R6: A non-maskable entry first writes the PC as a 32-bit word at SP-4, then writes the status word as a halfword at SP-8. It then delivers PC 0x40000008, SP-8, and the old status word with its enable bit (bit 11) cleared. It gives no acknowledge, and the request is consumed.
- R7: A maskable level L is taken only if the status enable bit (bit 11) is 1 and L is numerically less than the mask field in status bits [10:8]. Level 7 is never taken.
- R8: A maskable entry performs the same two stack writes. It then delivers PC 0x40000000 + vector[L], SP-8, and a status word with bits [10:8] = L and bit 11 = 0, and pulses the acknowledge with level L.
- R9: A maskable level stays pending after delivery and is taken again at a later boundary if the status word allows it, until the controller loads a new level.
- R10: A taken reset request pulses `rst_taken`, clears all vectors to 0, sets the pending level to 7 and drops any pending non-maskable request, with no stack write.
- R11: Decisions happen only in a cycle where `core_ready` is high and no entry sequence is in progress. Pending sources wait otherwise.
- R12: The PC write appears the cycle after the deciding edge, the status write one cycle later, and the entry result one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | Byte offset into the register bank |
| reg_size | input | 3 | Write size in bytes |
| reg_wdata | input | 16 | Write data, little-endian halfword |
| reg_rdata | output | 16 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| reg_err | output | 1 | Bad-size write flag |
| req_reset | input | 1 | Reset request pulse |
| req_nmi | input | 1 | Non-maskable request pulse |
| lvl_set | input | 1 | Load a new pending level |
| lvl_in | input | 3 | Pending maskable level, 7 = none |
| core_ready | input | 1 | Core is at an instruction boundary |
| core_pc | input | 32 | Current program counter |
| core_sp | input | 32 | Current stack pointer |
| core_psw | input | 16 | Current status word |
| mem_we | output | 1 | Stack write strobe |
| mem_half | output | 1 | Stack write is a halfword |
| mem_addr | output | 32 | Stack write address |
| mem_wdata | output | 32 | Stack write data |
| entry_valid | output | 1 | New core state is valid |
| entry_pc | output | 32 | Handler address |
| entry_sp | output | 32 | New stack pointer |
| entry_psw | output | 16 | New status word |
| ack_valid | output | 1 | Maskable entry acknowledge |
| ack_level | output | 3 | Level acknowledged |
| rst_taken | output | 1 | Reset request serviced |

## Verification
The bench works through the edges of the mask comparison: a level equal to the mask field, a cleared enable bit, and level 7. A design using less-or-equal, or ignoring the enable, would produce a stray entry that the scoreboard rejects. It also takes the same level twice across a status change and after a level update. A design that consumed the level on delivery would miss the second entry. Reset, non-maskable and maskable requests are raised together to catch a wrong priority order. Every stack write and entry is checked against the exact cycle offset from the deciding edge, so an extra or missing pipeline register shows up.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic [1:0] {S_IDLE, S_PCW, S_PSWW, S_CLR} seq_state_t;
  typedef enum logic [1:0] {K_NONE, K_NMI, K_LVL} entry_kind_t;
  typedef enum logic [1:0] {RS_NONE, RS_VEC, RS_MEMCTL, RS_MODE} rd_sel_t;
endpackage

// File: rtl/irqd_regfile.sv
module irqd_regfile import irqd_pkg::*; #(
  parameter int NVEC       = 7,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int MEMCTL_OFS = 'h20,
  parameter int MODE_OFS   = 'h40,
  parameter logic [15:0] MEMCTL_VAL = 16'h0000,
  parameter logic [15:0] MODE_VAL   = 16'h0000,
  localparam int IDX_W     = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [2:0]        reg_size,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              reg_err,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [IDX_W-1:0]  vec_raddr,
  output logic [DATA_W-1:0] vec_rdata
);
  localparam int WORD_W = ADDR_W - 2;

  logic [DATA_W-1:0] mem [NVEC];
  logic [DATA_W-1:0] bus_q;
  logic [WORD_W-1:0] word;
  logic              is_vec;
  logic [IDX_W-1:0]  bus_idx;
  logic              bus_we;
  logic              mem_we;
  logic [IDX_W-1:0]  mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  rd_sel_t           sel_d, sel_q;

  assign word    = reg_addr[ADDR_W-1:2];
  assign is_vec  = (reg_addr[1:0] == 2'b00) && (int'(word) < NVEC);
  assign bus_idx = IDX_W'(word);
  assign bus_we  = reg_wr && (reg_size == 3'd2) && is_vec;

  // the clearing sweep owns the write port while it runs
  assign mem_we    = clr_en || bus_we;
  assign mem_waddr = clr_en ? clr_idx : bus_idx;
  assign mem_wdata = clr_en ? '0 : reg_wdata;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
    bus_q     <= mem[is_vec ? bus_idx : '0];
    vec_rdata <= mem[vec_raddr];
  end

  always_comb begin
    sel_d = RS_NONE;
    if (is_vec)                             sel_d = RS_VEC;
    else if (int'(reg_addr) == MEMCTL_OFS)  sel_d = RS_MEMCTL;
    else if (int'(reg_addr) == MODE_OFS)    sel_d = RS_MODE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= RS_NONE;
      reg_rvalid <= 1'b0;
      reg_err    <= 1'b0;
    end else begin
      sel_q      <= reg_rd ? sel_d : RS_NONE;
      reg_rvalid <= reg_rd;
      reg_err    <= reg_wr && (reg_size != 3'd2);
    end
  end

  always_comb begin
    case (sel_q)
      RS_VEC:    reg_rdata = bus_q;
      RS_MEMCTL: reg_rdata = MEMCTL_VAL;
      RS_MODE:   reg_rdata = MODE_VAL;
      default:   reg_rdata = '0;
    endcase
  end

  AST_BAD_SIZE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_size != 3'd2) |=> reg_err); // R3
  AST_FLAG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    reg_err |-> $past(reg_wr)); // R3
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid); // R2
endmodule

// File: rtl/irqd_pending.sv
module irqd_pending #(
  parameter int LVL_W = 3,
  localparam logic [LVL_W-1:0] LVL_NONE = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_reset,
  input  logic             req_nmi,
  input  logic             lvl_set,
  input  logic [LVL_W-1:0] lvl_in,
  input  logic             rst_ack,
  input  logic             nmi_ack,
  input  logic [LVL_W-1:0] psw_lm,
  input  logic             psw_ie,
  output logic             take_rst,
  output logic             take_nmi,
  output logic             take_lvl,
  output logic [LVL_W-1:0] lvl_q
);
  logic pend_rst, pend_nmi;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_rst <= 1'b0;
      pend_nmi <= 1'b0;
      lvl_q    <= LVL_NONE;
    end else begin
      if (req_reset)    pend_rst <= 1'b1;
      else if (rst_ack) pend_rst <= 1'b0;

      if (req_nmi)                 pend_nmi <= 1'b1;
      else if (rst_ack || nmi_ack) pend_nmi <= 1'b0;

      if (rst_ack)      lvl_q <= LVL_NONE;
      else if (lvl_set) lvl_q <= lvl_in;
    end
  end

  assign take_rst = pend_rst;
  assign take_nmi = pend_nmi;
  assign take_lvl = psw_ie && (lvl_q < psw_lm);

  AST_NMI_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    (nmi_ack && !req_nmi) |=> !take_nmi); // R6
  AST_RST_DROPS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    rst_ack |=> (lvl_q == LVL_NONE)); // R10
  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (!lvl_set && !rst_ack) |=> $stable(lvl_q)); // R9
endmodule

// File: rtl/irqd_seq.sv
module irqd_seq import irqd_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int PSW_W  = 16,
  parameter int LVL_W  = 3,
  parameter int NVEC   = 7,
  parameter int VEC_W  = 16,
  parameter int LM_LSB = 8,
  parameter int IE_BIT = 11,
  parameter logic [31:0] NMI_PC   = 32'h4000_0008,
  parameter logic [31:0] LVL_BASE = 32'h4000_0000,
  localparam int IDX_W = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_ready,
  input  logic [ADDR_W-1:0] core_pc,
  input  logic [ADDR_W-1:0] core_sp,
  input  logic [PSW_W-1:0]  core_psw,
  input  logic              take_rst,
  input  logic              take_nmi,
  input  logic              take_lvl,
  input  logic [LVL_W-1:0]  lvl_q,
  output logic [IDX_W-1:0]  vec_raddr,
  input  logic [VEC_W-1:0]  vec_rdata,
  output logic              rst_ack,
  output logic              nmi_ack,
  output logic              clr_en,
  output logic [IDX_W-1:0]  clr_idx,
  output logic              mem_we,
  output logic              mem_half,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  output logic              entry_valid,
  output logic [ADDR_W-1:0] entry_pc,
  output logic [ADDR_W-1:0] entry_sp,
  output logic [PSW_W-1:0]  entry_psw,
  output logic              ack_valid,
  output logic [LVL_W-1:0]  ack_level,
  output logic              rst_taken
);
  seq_state_t        state;
  entry_kind_t       kind_q;
  logic [LVL_W-1:0]  lvl_cap;
  logic [ADDR_W-1:0] sp_cap;
  logic [PSW_W-1:0]  psw_cap;
  logic [VEC_W-1:0]  vec_q;
  logic [PSW_W-1:0]  new_psw;
  logic              decide;

  assign decide    = (state == S_IDLE) && core_ready && !entry_valid;
  assign rst_ack   = decide && take_rst;
  assign nmi_ack   = decide && !take_rst && take_nmi;
  assign clr_en    = (state == S_CLR);
  assign vec_raddr = (int'(lvl_q) < NVEC) ? IDX_W'(lvl_q) : '0;

  always_comb begin
    new_psw         = psw_cap;
    new_psw[IE_BIT] = 1'b0;
    if (kind_q == K_LVL) new_psw[LM_LSB +: LVL_W] = lvl_cap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_CLR;
      clr_idx     <= '0;
      kind_q      <= K_NONE;
      lvl_cap     <= '0;
      sp_cap      <= '0;
      psw_cap     <= '0;
      vec_q       <= '0;
      mem_we      <= 1'b0;
      mem_half    <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      entry_valid <= 1'b0;
      entry_pc    <= '0;
      entry_sp    <= '0;
      entry_psw   <= '0;
      ack_valid   <= 1'b0;
      ack_level   <= '0;
      rst_taken   <= 1'b0;
    end else begin
      mem_we      <= 1'b0;
      entry_valid <= 1'b0;
      ack_valid   <= 1'b0;
      rst_taken   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (decide) begin
            if (take_rst) begin
              state     <= S_CLR;
              clr_idx   <= '0;
              rst_taken <= 1'b1;
            end else if (take_nmi || take_lvl) begin
              kind_q    <= take_nmi ? K_NMI : K_LVL;
              lvl_cap   <= lvl_q;
              sp_cap    <= core_sp;
              psw_cap   <= core_psw;
              mem_we    <= 1'b1;
              mem_half  <= 1'b0;
              mem_addr  <= core_sp - ADDR_W'(4);
              mem_wdata <= core_pc;
              state     <= S_PCW;
            end
          end
        end
        S_PCW: begin
          vec_q     <= vec_rdata;
          mem_we    <= 1'b1;
          mem_half  <= 1'b1;
          mem_addr  <= sp_cap - ADDR_W'(8);
          mem_wdata <= ADDR_W'(psw_cap);
          state     <= S_PSWW;
        end
        S_PSWW: begin
          entry_valid <= 1'b1;
          entry_pc    <= (kind_q == K_NMI) ? NMI_PC : (LVL_BASE + ADDR_W'(vec_q));
          entry_sp    <= sp_cap - ADDR_W'(8);
          entry_psw   <= new_psw;
          ack_valid   <= (kind_q == K_LVL);
          ack_level   <= lvl_cap;
          state       <= S_IDLE;
        end
        default: begin
          if (int'(clr_idx) == NVEC - 1) state <= S_IDLE;
          else clr_idx <= clr_idx + 1'b1;
        end
      endcase
    end
  end

  AST_PSW_FOLLOWS_PC: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_half) |=> (mem_we && mem_half && mem_addr == $past(mem_addr) - ADDR_W'(4))); // R6
  AST_ENTRY_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_half) |=> entry_valid); // R12
  AST_ACK_NEVER_NONE: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> (ack_level != '1)); // R7
  AST_ACK_WITH_ENTRY: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> entry_valid); // R8
  AST_ONE_OUTPUT_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, entry_valid, rst_taken})); // R11
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit import irqd_pkg::*; #(
  parameter int NVEC   = 7,
  parameter int RADDR_W = 7,
  parameter int VEC_W  = 16,
  parameter int ADDR_W = 32,
  parameter int PSW_W  = 16,
  parameter int LVL_W  = 3,
  parameter int LM_LSB = 8,
  parameter int IE_BIT = 11,
  parameter logic [15:0] MEMCTL_VAL = 16'h0123,
  parameter logic [15:0] MODE_VAL   = 16'h00A5,
  parameter logic [31:0] NMI_PC     = 32'h4000_0008,
  parameter logic [31:0] LVL_BASE   = 32'h4000_0000,
  localparam int IDX_W = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [2:0]         reg_size,
  input  logic [VEC_W-1:0]   reg_wdata,
  output logic [VEC_W-1:0]   reg_rdata,
  output logic               reg_rvalid,
  output logic               reg_err,
  input  logic               req_reset,
  input  logic               req_nmi,
  input  logic               lvl_set,
  input  logic [LVL_W-1:0]   lvl_in,
  input  logic               core_ready,
  input  logic [ADDR_W-1:0]  core_pc,
  input  logic [ADDR_W-1:0]  core_sp,
  input  logic [PSW_W-1:0]   core_psw,
  output logic               mem_we,
  output logic               mem_half,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [ADDR_W-1:0]  mem_wdata,
  output logic               entry_valid,
  output logic [ADDR_W-1:0]  entry_pc,
  output logic [ADDR_W-1:0]  entry_sp,
  output logic [PSW_W-1:0]   entry_psw,
  output logic               ack_valid,
  output logic [LVL_W-1:0]   ack_level,
  output logic               rst_taken
);
  logic             clr_en, rst_ack, nmi_ack;
  logic             take_rst, take_nmi, take_lvl;
  logic [IDX_W-1:0] clr_idx, vec_raddr;
  logic [VEC_W-1:0] vec_rdata;
  logic [LVL_W-1:0] lvl_q;

  irqd_regfile #(
    .NVEC(NVEC), .ADDR_W(RADDR_W), .DATA_W(VEC_W),
    .MEMCTL_VAL(MEMCTL_VAL), .MODE_VAL(MODE_VAL)
  ) u_regs (
    .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_size, .reg_wdata,
    .reg_rdata, .reg_rvalid, .reg_err,
    .clr_en, .clr_idx, .vec_raddr, .vec_rdata
  );

  irqd_pending #(.LVL_W(LVL_W)) u_pend (
    .clk, .rst, .req_reset, .req_nmi, .lvl_set, .lvl_in,
    .rst_ack, .nmi_ack,
    .psw_lm(core_psw[LM_LSB +: LVL_W]),
    .psw_ie(core_psw[IE_BIT]),
    .take_rst, .take_nmi, .take_lvl, .lvl_q
  );

  irqd_seq #(
    .ADDR_W(ADDR_W), .PSW_W(PSW_W), .LVL_W(LVL_W), .NVEC(NVEC), .VEC_W(VEC_W),
    .LM_LSB(LM_LSB), .IE_BIT(IE_BIT), .NMI_PC(NMI_PC), .LVL_BASE(LVL_BASE)
  ) u_seq (
    .clk, .rst, .core_ready, .core_pc, .core_sp, .core_psw,
    .take_rst, .take_nmi, .take_lvl, .lvl_q,
    .vec_raddr, .vec_rdata, .rst_ack, .nmi_ack, .clr_en, .clr_idx,
    .mem_we, .mem_half, .mem_addr, .mem_wdata,
    .entry_valid, .entry_pc, .entry_sp, .entry_psw,
    .ack_valid, .ack_level, .rst_taken
  );
endmodule

// File: tb/irq_entry_unit_test.sv
module irq_entry_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [6:0]  reg_addr = 0;
  logic [2:0]  reg_size = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        reg_rvalid, reg_err;
  logic        req_reset = 0, req_nmi = 0, lvl_set = 0;
  logic [2:0]  lvl_in = 0;
  logic        core_ready = 0;
  logic [31:0] core_pc = 0, core_sp = 0;
  logic [15:0] core_psw = 0;
  logic        mem_we, mem_half, entry_valid, ack_valid, rst_taken;
  logic [31:0] mem_addr, mem_wdata, entry_pc, entry_sp;
  logic [15:0] entry_psw;
  logic [2:0]  ack_level;

  irq_entry_unit uut (.*);

  always #5 clk = ~clk;

  typedef struct {
    bit          is_entry;
    int          off;
    logic [31:0] a;
    logic [31:0] d;
    logic        half;
    logic [15:0] psw;
    logic        ack;
    logic [2:0]  lvl;
    string       tag;
  } item_t;

  item_t       exp_q[$];
  int          n_tests = 0, n_fail = 0;
  int          cyc = 0;
  int          dec_cyc = 0;
  bit          saw_rst = 0;
  logic [15:0] vec_m [7];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard items as the design emits them
  always @(negedge clk) begin
    if (!rst) begin
      if (rst_taken) saw_rst = 1;
      if (mem_we || entry_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R11 unexpected event", {31'b0, entry_valid}, 32'h0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(entry_valid == it.is_entry, {it.tag, " kind"}, {31'b0, entry_valid}, {31'b0, it.is_entry});
          chk(cyc == dec_cyc + it.off, "R12 cycle", cyc, dec_cyc + it.off);
          if (it.is_entry) begin
            chk(entry_pc == it.a, {it.tag, " pc"}, entry_pc, it.a);
            chk(entry_sp == it.d, {it.tag, " sp"}, entry_sp, it.d);
            chk(entry_psw == it.psw, {it.tag, " psw"}, {16'b0, entry_psw}, {16'b0, it.psw});
            chk(ack_valid == it.ack, {it.tag, " ack"}, {31'b0, ack_valid}, {31'b0, it.ack});
            if (it.ack) chk(ack_level == it.lvl, {it.tag, " ack level"}, {29'b0, ack_level}, {29'b0, it.lvl});
          end else begin
            chk(mem_addr == it.a && mem_half == it.half, {it.tag, " wr addr"}, mem_addr, it.a);
            chk(mem_wdata == it.d, {it.tag, " wr data"}, mem_wdata, it.d);
          end
        end
      end
    end
  end

  function automatic logic [15:0] mkpsw(logic [2:0] lm, bit ie);
    return 16'h0005 | (16'(ie) << 11) | (16'(lm) << 8);
  endfunction

  function automatic item_t mk(bit e, int off, logic [31:0] a, logic [31:0] d, logic h,
                               logic [15:0] p, logic k, logic [2:0] l, string t);
    item_t it;
    it.is_entry = e; it.off = off; it.a = a; it.d = d; it.half = h;
    it.psw = p; it.ack = k; it.lvl = l; it.tag = t;
    return it;
  endfunction

  task automatic push_stack(string tag);
    exp_q.push_back(mk(0, 0, core_sp - 4, core_pc, 0, 0, 0, 0, tag));
    exp_q.push_back(mk(0, 1, core_sp - 8, {16'b0, core_psw}, 1, 0, 0, 0, tag));
  endtask

  task automatic push_nmi();
    push_stack("R6");
    exp_q.push_back(mk(1, 2, 32'h4000_0008, core_sp - 8, 0, core_psw & ~16'h0800, 0, 0, "R6"));
  endtask

  task automatic push_lvl(logic [2:0] l, string tag);
    push_stack(tag);
    exp_q.push_back(mk(1, 2, 32'h4000_0000 + {16'b0, vec_m[l]}, core_sp - 8, 0,
                       (core_psw & ~16'h0F00 & ~16'h0800) | (16'(l) << 8), 1, l, tag));
  endtask

  task automatic step(string tag);
    @(negedge clk);
    core_ready = 1;
    dec_cyc = cyc + 1;
    @(negedge clk);
    core_ready = 0;
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  task automatic rd(logic [6:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    chk(reg_rvalid && reg_rdata == exp, tag, {15'b0, reg_rvalid, reg_rdata}, {16'h1, exp});
  endtask

  task automatic wr(logic [6:0] a, logic [15:0] d, logic [2:0] sz, bit exp_err, string tag);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; reg_size = sz;
    @(negedge clk);
    reg_wr = 0;
    chk(reg_err == exp_err, tag, {31'b0, reg_err}, {31'b0, exp_err});
  endtask

  task automatic pulse_nmi();
    @(negedge clk); req_nmi = 1; @(negedge clk); req_nmi = 0;
  endtask

  task automatic set_level(logic [2:0] l);
    @(negedge clk); lvl_set = 1; lvl_in = l; @(negedge clk); lvl_set = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    core_pc = 32'h0000_1230; core_sp = 32'h0000_8000; core_psw = mkpsw(3'd7, 1);
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (12) @(negedge clk);
    chk(!mem_we && !entry_valid && !ack_valid, "R1 outputs idle", {29'b0, mem_we, entry_valid, ack_valid}, 0);
    for (int k = 0; k < 7; k++) begin
      vec_m[k] = 16'h0;
      rd(7'(4 * k), 16'h0, "R1 vector cleared");
    end
    // no level pending: enabled boundary yields nothing
    step("R1");

    // R2 vector writes and readback
    for (int k = 0; k < 7; k++) begin
      vec_m[k] = 16'h0100 + 16'(k * 16'h0111);
      wr(7'(4 * k), vec_m[k], 3'd2, 0, "R3 good size no flag");
    end
    for (int k = 0; k < 7; k++) rd(7'(4 * k), vec_m[k], "R2 vector readback");

    // R3 bad sizes
    wr(7'h08, 16'hDEAD, 3'd1, 1, "R3 one byte flagged");
    wr(7'h08, 16'hDEAD, 3'd4, 1, "R3 four bytes flagged");
    rd(7'h08, vec_m[2], "R3 vector unchanged");

    // R4 constants and ignored writes
    rd(7'h20, 16'h0123, "R4 memctl read");
    rd(7'h40, 16'h00A5, "R4 mode read");
    wr(7'h20, 16'hFFFF, 3'd2, 0, "R4 memctl write");
    wr(7'h40, 16'hFFFF, 3'd2, 0, "R4 mode write");
    wr(7'h1C, 16'hBEEF, 3'd2, 0, "R4 hole write");
    wr(7'h02, 16'hBEEF, 3'd2, 0, "R4 misaligned write");
    rd(7'h20, 16'h0123, "R4 memctl unchanged");
    rd(7'h40, 16'h00A5, "R4 mode unchanged");
    rd(7'h1C, 16'h0000, "R4 hole reads zero");
    rd(7'h00, vec_m[0], "R4 vector0 unchanged");
    rd(7'h18, vec_m[6], "R4 vector6 unchanged");

    // R6 non-maskable entry, consumed after use
    core_psw = mkpsw(3'd2, 1);
    pulse_nmi();
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0 && !mem_we, "R11 waits for core_ready", 0, 0);
    push_nmi();
    step("R6");
    step("R6 consumed");

    // R8 maskable entry
    core_pc = 32'h0000_2000; core_sp = 32'h0000_7000; core_psw = mkpsw(3'd5, 1);
    set_level(3'd3);
    push_lvl(3'd3, "R8");
    step("R8");
    // R7 gating
    core_psw = mkpsw(3'd5, 0);
    step("R7 disabled");
    core_psw = mkpsw(3'd3, 1);
    step("R7 equal mask");
    // R9 still pending
    core_psw = mkpsw(3'd4, 1);
    push_lvl(3'd3, "R9");
    step("R9 retaken");
    set_level(3'd0);
    push_lvl(3'd0, "R9 new level");
    step("R9 new level");
    set_level(3'd7);
    core_psw = mkpsw(3'd7, 1);
    step("R7 level none");

    // R5 priority
    set_level(3'd2);
    pulse_nmi();
    push_nmi();
    step("R5 nmi first");
    push_lvl(3'd2, "R5 then level");
    step("R5 then level");

    // R10 reset request beats all
    pulse_nmi();
    @(negedge clk); req_reset = 1; @(negedge clk); req_reset = 0;
    saw_rst = 0;
    step("R5 reset first");
    chk(saw_rst, "R10 reset pulse", {31'b0, saw_rst}, 1);
    repeat (10) @(negedge clk);
    for (int k = 0; k < 7; k++) begin
      vec_m[k] = 16'h0;
      rd(7'(4 * k), 16'h0, "R10 vector cleared");
    end
    step("R10 nothing left pending");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule